// File: doc/BRIEF.md
# State-Pair Compatibility Finder

This block takes a small state table of a one-input sequential machine and works out which pairs of states may be merged. Each state has a next state and an output for input 0 and for input 1, and each of these four fields has its own flag saying whether it is specified. An unspecified field is a don't-care. Software or a neighbouring block writes the rows through a write port one row at a time, pulses `start`, and waits for `done`.

The engine holds one mark bit for each unordered pair of distinct states. It first marks every pair whose specified outputs disagree. It then makes repeated sweeps over the pairs, visiting one pair per clock in a fixed order. In each sweep it marks a pair when one of the pairs it implies through its next states is already marked. It stops after a sweep that adds no mark. The pairs left unmarked are compatible. Because don't-cares are allowed, compatibility is not transitive. The result can be read one pair at a time through an address port, or all at once as a flat vector, and it is valid while `done` is high.

Top module: `stc_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `compat_vec` is all zeros and `rd_compat` is 0.
- R2: A pair whose two outputs are both specified and different, for input 0 or for input 1, is reported incompatible.
- R3: An output that is unspecified on either side never causes a conflict. A table with every field unspecified reports every pair compatible.
- R4: The engine marks every pair that implies a marked pair, until no more marks are added. For the 8-state example table A..H = 0..7, with next states under x=0/x=1 and outputs A:D,C,0 B:F,H,0 C:E,D,1 D:A,E,0 E:C,A,1 F:F,B,1 G:B,H,0 H:C,G,1, exactly A-D and C-E come out compatible.
- R5: An implied pair made of one state twice, or equal to the pair under test, adds no constraint. If the next state on either side is unspecified for an input, that input gives no implied pair.
- R6: Pair (lo,hi) with lo<hi has index hi*(hi-1)/2+lo. Bit k of `compat_vec` and `rd_compat` at `rd_addr`=k are 1 exactly when pair k is compatible and `done` is high. An address of NUM_ST*(NUM_ST-1)/2 or more reads 0.
- R7: While `busy` is high, `start` and `wr_en` are ignored. The result and the stored table are unchanged by them.
- R8: `busy` rises in the cycle after an accepted `start` and `done` follows within NPAIR*(NPAIR+2)+2 cycles, where NPAIR is the number of pairs. `done` and the result then hold until the next accepted `start`, and `busy` and `done` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table row |
| wr_row | input | SW | Row (state) being written |
| wr_ns0 | input | SW | Next state for input 0 |
| wr_ns0_vld | input | 1 | Next state for input 0 is specified |
| wr_ns1 | input | SW | Next state for input 1 |
| wr_ns1_vld | input | 1 | Next state for input 1 is specified |
| wr_z0 | input | 1 | Output for input 0 |
| wr_z0_vld | input | 1 | Output for input 0 is specified |
| wr_z1 | input | 1 | Output for input 1 |
| wr_z1_vld | input | 1 | Output for input 1 is specified |
| start | input | 1 | Start a run (accepted when not busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid |
| rd_addr | input | PW | Pair index to read |
| rd_compat | output | 1 | Selected pair is compatible |
| compat_vec | output | NPAIR | One compatibility bit per pair |

## Verification
A wrong mark bit shows up as a flipped bit in `compat_vec` and at the matching `rd_addr` as soon as `done` rises. The bench compares both against a reference fixed point for the worked example, for degenerate tables and for random tables with don't-cares. A broken sweep loop shows either as a missing mark, when it ends early, or as `done` arriving late or never, which the cycle bound catches. A write or start that leaks in while the engine is busy shows as a result that differs from the original table's result, either in the same run or in a rerun with no new writes.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {S_IDLE, S_OUTP, S_IMP, S_DONE} stc_state_e;

  // linear index of unordered pair lo<hi
  function automatic int unsigned pair_index(input int unsigned lo, input int unsigned hi);
    return (hi * (hi - 1)) / 2 + lo;
  endfunction
endpackage

// File: rtl/stc_state_table.sv
module stc_state_table #(
  parameter int NUM_ST = 8,
  localparam int SW = $clog2(NUM_ST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_row,
  input  logic [SW-1:0] wr_ns0,
  input  logic          wr_ns0_vld,
  input  logic [SW-1:0] wr_ns1,
  input  logic          wr_ns1_vld,
  input  logic          wr_z0,
  input  logic          wr_z0_vld,
  input  logic          wr_z1,
  input  logic          wr_z1_vld,
  input  logic [SW-1:0] rd_a,
  input  logic [SW-1:0] rd_b,
  output logic [SW-1:0] ns_a [2],
  output logic [1:0]    nsv_a,
  output logic [1:0]    z_a,
  output logic [1:0]    zv_a,
  output logic [SW-1:0] ns_b [2],
  output logic [1:0]    nsv_b,
  output logic [1:0]    z_b,
  output logic [1:0]    zv_b
);
  logic [SW-1:0] ns0_q [NUM_ST];
  logic [SW-1:0] ns1_q [NUM_ST];
  logic [1:0]    nsv_q [NUM_ST];
  logic [1:0]    z_q   [NUM_ST];
  logic [1:0]    zv_q  [NUM_ST];
  logic          we;

  assign we = wr_en && !hold;

  for (genvar r = 0; r < NUM_ST; r++) begin : g_row
    logic row_we;
    assign row_we = we && (wr_row == SW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ns0_q[r] <= '0;
        ns1_q[r] <= '0;
        nsv_q[r] <= '0;
        z_q[r]   <= '0;
        zv_q[r]  <= '0;
      end else if (row_we) begin
        ns0_q[r] <= wr_ns0;
        ns1_q[r] <= wr_ns1;
        nsv_q[r] <= {wr_ns1_vld, wr_ns0_vld};
        z_q[r]   <= {wr_z1, wr_z0};
        zv_q[r]  <= {wr_z1_vld, wr_z0_vld};
      end
    end

    assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && wr_en) |=> ($stable(ns0_q[r]) && $stable(ns1_q[r]) && $stable(nsv_q[r])
                           && $stable(z_q[r]) && $stable(zv_q[r])));
  end

  always_comb begin
    ns_a[0] = ns0_q[rd_a];
    ns_a[1] = ns1_q[rd_a];
    nsv_a   = nsv_q[rd_a];
    z_a     = z_q[rd_a];
    zv_a    = zv_q[rd_a];
    ns_b[0] = ns0_q[rd_b];
    ns_b[1] = ns1_q[rd_b];
    nsv_b   = nsv_q[rd_b];
    z_b     = z_q[rd_b];
    zv_b    = zv_q[rd_b];
  end
endmodule

// File: rtl/stc_pair_walker.sv
module stc_pair_walker #(
  parameter int NUM_ST = 8,
  localparam int SW = $clog2(NUM_ST),
  localparam int NPAIR = NUM_ST * (NUM_ST - 1) / 2,
  localparam int PW = $clog2(NPAIR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] idx,
  output logic [SW-1:0] lo,
  output logic [SW-1:0] hi,
  output logic          last
);
  logic [PW-1:0] idx_d;
  logic [SW-1:0] lo_d, hi_d;

  assign last = (idx == PW'(NPAIR - 1));

  always_comb begin
    idx_d = idx;
    lo_d  = lo;
    hi_d  = hi;
    if (clr) begin
      idx_d = '0;
      lo_d  = '0;
      hi_d  = SW'(1);
    end else if (adv) begin
      idx_d = idx + PW'(1);
      if (lo == hi - SW'(1)) begin
        lo_d = '0;
        hi_d = hi + SW'(1);
      end else begin
        lo_d = lo + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      lo  <= '0;
      hi  <= SW'(1);
    end else if (clr || adv) begin
      idx <= idx_d;
      lo  <= lo_d;
      hi  <= hi_d;
    end
  end

  assert_index_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo < hi) && (int'(idx) == int'(stc_pkg::pair_index(int'(lo), int'(hi)))));
endmodule

// File: rtl/stc_pair_matrix.sv
module stc_pair_matrix #(
  parameter int NUM_ST = 8,
  localparam int NPAIR = NUM_ST * (NUM_ST - 1) / 2,
  localparam int PW = $clog2(NPAIR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic [PW-1:0]    set_idx,
  output logic [NPAIR-1:0] mark
);
  logic [NPAIR-1:0] mark_d;

  always_comb begin
    mark_d = mark;
    if (clr) mark_d = '0;
    else if (set_en) mark_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark <= '0;
    else if (clr || set_en) mark <= mark_d;
  end

  assert_mark_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((mark & $past(mark)) == $past(mark)));
endmodule

// File: rtl/stc_engine.sv
module stc_engine #(
  parameter int NUM_ST = 8,
  localparam int SW = $clog2(NUM_ST),
  localparam int NPAIR = NUM_ST * (NUM_ST - 1) / 2,
  localparam int PW = $clog2(NPAIR),
  localparam int CW = $clog2(NPAIR + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_row,
  input  logic [SW-1:0]    wr_ns0,
  input  logic             wr_ns0_vld,
  input  logic [SW-1:0]    wr_ns1,
  input  logic             wr_ns1_vld,
  input  logic             wr_z0,
  input  logic             wr_z0_vld,
  input  logic             wr_z1,
  input  logic             wr_z1_vld,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [PW-1:0]    rd_addr,
  output logic             rd_compat,
  output logic [NPAIR-1:0] compat_vec
);
  import stc_pkg::*;

  stc_state_e st_q, st_d;
  logic          go, walk_clr, again, conflict, imp_hit, set_en;
  logic          changed_q, changed_d;
  logic [CW-1:0] sweep_q, sweep_d;
  logic [PW-1:0] idx;
  logic [SW-1:0] lo, hi;
  logic          last;
  logic [NPAIR-1:0] mark;
  logic [SW-1:0] ns_a [2];
  logic [SW-1:0] ns_b [2];
  logic [1:0]    nsv_a, nsv_b, z_a, z_b, zv_a, zv_b, hit;

  assign busy = (st_q == S_OUTP) || (st_q == S_IMP);
  assign done = (st_q == S_DONE);
  assign go   = start && !busy;

  stc_state_table #(.NUM_ST(NUM_ST)) u_table (
    .clk(clk), .rst_n(rst_n), .hold(busy), .wr_en(wr_en), .wr_row(wr_row),
    .wr_ns0(wr_ns0), .wr_ns0_vld(wr_ns0_vld), .wr_ns1(wr_ns1), .wr_ns1_vld(wr_ns1_vld),
    .wr_z0(wr_z0), .wr_z0_vld(wr_z0_vld), .wr_z1(wr_z1), .wr_z1_vld(wr_z1_vld),
    .rd_a(lo), .rd_b(hi),
    .ns_a(ns_a), .nsv_a(nsv_a), .z_a(z_a), .zv_a(zv_a),
    .ns_b(ns_b), .nsv_b(nsv_b), .z_b(z_b), .zv_b(zv_b));

  stc_pair_walker #(.NUM_ST(NUM_ST)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(walk_clr), .adv(busy),
    .idx(idx), .lo(lo), .hi(hi), .last(last));

  stc_pair_matrix #(.NUM_ST(NUM_ST)) u_mat (
    .clk(clk), .rst_n(rst_n), .clr(go), .set_en(set_en), .set_idx(idx), .mark(mark));

  assign conflict = |(zv_a & zv_b & (z_a ^ z_b));

  // implied pair lookup, one per input value
  for (genvar x = 0; x < 2; x++) begin : g_imp
    logic [SW-1:0] p_lo, p_hi;
    logic          useful;
    assign p_lo   = (ns_a[x] < ns_b[x]) ? ns_a[x] : ns_b[x];
    assign p_hi   = (ns_a[x] < ns_b[x]) ? ns_b[x] : ns_a[x];
    assign useful = nsv_a[x] && nsv_b[x] && (p_lo != p_hi) && !((p_lo == lo) && (p_hi == hi));
    assign hit[x] = useful && mark[PW'(pair_index(int'(p_lo), int'(p_hi)))];
  end

  assign imp_hit  = |hit;
  assign set_en   = ((st_q == S_OUTP) && conflict) ||
                    ((st_q == S_IMP) && imp_hit && !mark[idx]);
  assign again    = changed_q || ((st_q == S_IMP) && set_en);
  assign walk_clr = go || (busy && last);

  always_comb begin
    st_d      = st_q;
    changed_d = changed_q;
    sweep_d   = sweep_q;
    if (go) begin
      st_d      = S_OUTP;
      changed_d = 1'b0;
      sweep_d   = '0;
    end else if (st_q == S_OUTP) begin
      if (last) begin
        st_d    = S_IMP;
        sweep_d = CW'(1);
      end
    end else if (st_q == S_IMP) begin
      if (set_en) changed_d = 1'b1;
      if (last) begin
        changed_d = 1'b0;
        if (again) sweep_d = sweep_q + CW'(1);
        else       st_d    = S_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      changed_q <= 1'b0;
      sweep_q   <= '0;
    end else begin
      st_q      <= st_d;
      changed_q <= changed_d;
      sweep_q   <= sweep_d;
    end
  end

  assign compat_vec = done ? ~mark : '0;
  assign rd_compat  = done && (int'(rd_addr) < NPAIR) && !mark[rd_addr];

  assert_sweep_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IMP) |-> (int'(sweep_q) <= NPAIR + 1));
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(compat_vec)));
  assert_out_conflict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_OUTP) && conflict) |=> (mark[$past(idx)] == 1'b1));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IMP && !last) |=> (st_q == S_IMP));
endmodule

// File: tb/stc_engine_bench.sv
module stc_engine_bench;
  localparam int N = 8;
  localparam int SW = 3;
  localparam int NP = 28;
  localparam int PW = 5;
  localparam int BOUND = NP * (NP + 2) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_ns0_vld = 0, wr_ns1_vld = 0, wr_z0 = 0, wr_z0_vld = 0, wr_z1 = 0, wr_z1_vld = 0;
  logic [SW-1:0] wr_row = 0, wr_ns0 = 0, wr_ns1 = 0;
  logic start = 0;
  logic busy, done, rd_compat;
  logic [PW-1:0] rd_addr = 0;
  logic [NP-1:0] compat_vec;

  int errors = 0, checks = 0, cyc = 0;

  int m_ns [N][2];
  bit m_nv [N][2];
  bit m_z  [N][2];
  bit m_zv [N][2];

  always #4 clk = ~clk;

  stc_engine #(.NUM_ST(N)) u_stc_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_ns0(wr_ns0), .wr_ns0_vld(wr_ns0_vld), .wr_ns1(wr_ns1), .wr_ns1_vld(wr_ns1_vld),
    .wr_z0(wr_z0), .wr_z0_vld(wr_z0_vld), .wr_z1(wr_z1), .wr_z1_vld(wr_z1_vld),
    .start(start), .busy(busy), .done(done), .rd_addr(rd_addr), .rd_compat(rd_compat),
    .compat_vec(compat_vec));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pidx(int lo, int hi);
    return hi * (hi - 1) / 2 + lo;
  endfunction

  // reference fixed point of compatible pairs
  function automatic logic [NP-1:0] ref_compat();
    bit mk [N][N];
    bit chg;
    logic [NP-1:0] v;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mk[i][j] = 0;
    for (int j = 1; j < N; j++)
      for (int i = 0; i < j; i++)
        for (int x = 0; x < 2; x++)
          if (m_zv[i][x] && m_zv[j][x] && m_z[i][x] != m_z[j][x]) mk[i][j] = 1;
    chg = 1;
    while (chg) begin
      chg = 0;
      for (int j = 1; j < N; j++)
        for (int i = 0; i < j; i++)
          if (!mk[i][j])
            for (int x = 0; x < 2; x++)
              if (m_nv[i][x] && m_nv[j][x]) begin
                int a, b, l, h;
                a = m_ns[i][x]; b = m_ns[j][x];
                l = (a < b) ? a : b; h = (a < b) ? b : a;
                if (l != h && !(l == i && h == j) && mk[l][h]) begin
                  mk[i][j] = 1; chg = 1;
                end
              end
    end
    for (int j = 1; j < N; j++)
      for (int i = 0; i < j; i++) v[pidx(i, j)] = !mk[i][j];
    return v;
  endfunction

  task automatic put_row(input int s, input int n0, input bit v0, input int n1, input bit v1,
                         input bit z0, input bit zv0, input bit z1, input bit zv1, input bit model);
    @(negedge clk);
    wr_en = 1; wr_row = SW'(s);
    wr_ns0 = SW'(n0); wr_ns0_vld = v0; wr_ns1 = SW'(n1); wr_ns1_vld = v1;
    wr_z0 = z0; wr_z0_vld = zv0; wr_z1 = z1; wr_z1_vld = zv1;
    if (model) begin
      m_ns[s][0] = n0; m_nv[s][0] = v0; m_ns[s][1] = n1; m_nv[s][1] = v1;
      m_z[s][0] = z0; m_zv[s][0] = zv0; m_z[s][1] = z1; m_zv[s][1] = zv1;
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input string req);
    int n;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check({req, " busy after start"}, 64'(busy), 64'd1);
    n = 1;
    while (!done && n < BOUND + 50) begin
      @(negedge clk);
      n++;
    end
    check("R8 done within bound", 64'(n <= BOUND), 64'd1);
  endtask

  task automatic check_result(input string req);
    logic [NP-1:0] e;
    e = ref_compat();
    check(req, 64'(compat_vec), 64'(e));
  endtask

  initial begin
    logic [NP-1:0] e0;
    void'($urandom(32'h1d2c3b4a));
    for (int s = 0; s < N; s++) begin
      m_ns[s][0] = 0; m_ns[s][1] = 0; m_nv[s][0] = 0; m_nv[s][1] = 0;
      m_z[s][0] = 0; m_z[s][1] = 0; m_zv[s][0] = 0; m_zv[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 vec", 64'(compat_vec), 0);
    check("R1 rd", 64'(rd_compat), 0);
    rst_n = 1;
    @(negedge clk);

    // R3: all fields unspecified -> all compatible
    run("R3");
    check("R3 all unspecified", 64'(compat_vec), 64'({NP{1'b1}}));

    // R4: worked example
    put_row(0, 3, 1, 2, 1, 0, 1, 0, 1, 1);
    put_row(1, 5, 1, 7, 1, 0, 1, 0, 1, 1);
    put_row(2, 4, 1, 3, 1, 1, 1, 1, 1, 1);
    put_row(3, 0, 1, 4, 1, 0, 1, 0, 1, 1);
    put_row(4, 2, 1, 0, 1, 1, 1, 1, 1, 1);
    put_row(5, 5, 1, 1, 1, 1, 1, 1, 1, 1);
    put_row(6, 1, 1, 7, 1, 0, 1, 0, 1, 1);
    put_row(7, 2, 1, 6, 1, 1, 1, 1, 1, 1);
    run("R4");
    check("R4 example A-D and C-E only", 64'(compat_vec),
          64'((NP'(1) << pidx(0, 3)) | (NP'(1) << pidx(2, 4))));
    check_result("R4 example vs reference");
    for (int k = 0; k < 32; k++) begin
      rd_addr = PW'(k);
      #1;
      check($sformatf("R6 rd_addr %0d", k), 64'(rd_compat),
            64'((k < NP) ? compat_vec[k % NP] : 1'b0));
    end
    repeat (5) @(negedge clk);
    check("R8 done holds", 64'(done), 1);

    // R7: start and writes while busy are ignored
    e0 = ref_compat();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    wr_en = 1; wr_row = 0; wr_ns0 = 1; wr_ns0_vld = 1; wr_z0 = 1; wr_z0_vld = 1;
    start = 1;
    @(negedge clk); wr_en = 0; start = 0;
    while (!done) @(negedge clk);
    check("R7 write during busy ignored", 64'(compat_vec), 64'(e0));
    run("R7");
    check("R7 table unchanged on rerun", 64'(compat_vec), 64'(e0));

    // R2: distinct outputs on x=1 only, self loops -> nothing compatible except equal-output pairs
    for (int s = 0; s < N; s++) put_row(s, s, 1, s, 1, 0, 1, s % 2, 1, 1);
    run("R2");
    check_result("R2 output conflict x=1");
    check("R2 pair 0-1 incompatible", 64'(compat_vec[pidx(0, 1)]), 0);
    check("R5 pair 0-2 self loops compatible", 64'(compat_vec[pidx(0, 2)]), 1);

    // R5: pair implies itself / unspecified next states
    for (int s = 0; s < N; s++) put_row(s, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    put_row(0, 1, 1, 0, 1, 0, 1, 0, 0, 1);
    put_row(1, 0, 1, 1, 1, 0, 1, 0, 0, 1);
    put_row(2, 3, 1, 2, 0, 0, 1, 0, 0, 1);
    put_row(3, 4, 1, 5, 0, 1, 1, 0, 0, 1);
    run("R5");
    check_result("R5 reference");
    check("R5 self-implied 0-1 compatible", 64'(compat_vec[pidx(0, 1)]), 1);
    check("R5 2-3 conflict", 64'(compat_vec[pidx(2, 3)]), 0);

    // random tables with don't-cares
    for (int t = 0; t < 30; t++) begin
      for (int s = 0; s < N; s++)
        put_row(s, $urandom_range(N - 1), $urandom_range(3) != 0, $urandom_range(N - 1),
                $urandom_range(3) != 0, 1'($urandom_range(1)), $urandom_range(3) != 0,
                1'($urandom_range(1)), $urandom_range(3) != 0, 1);
      run("R4");
      check_result($sformatf("R4 random table %0d", t));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule